// File: doc/BRIEF.md
# Keyed Index/Data Configuration Space

This block is the configuration front end of a legacy-bus peripheral controller. It listens on a byte-wide I/O bus with an address, a read strobe, a write strobe, a write data byte and a registered read data byte. Two adjacent bus addresses form the interface. The lower one is the index port and the upper one is the data port. After reset the space is locked. The host opens it by writing a four-byte magic key to the index port. It then picks a register by writing its number to the index port, and reads or writes that register through the data port. A dedicated exit command closes the space again.

Indices below 0x30 are global. They hold a logical-device selector and read-only identity bytes. Indices from 0x30 up are banked by the selected logical device. Device 7 is the GPIO device, and it exposes a read-only 16-bit I/O base address as two bytes. The identity and base values are fixed by parameters. 16-bit values are read as two separate byte accesses, high byte first.

The bus has no back-pressure. Every strobe is taken in the cycle it is high. A read strobe and a write strobe are never asserted in the same cycle.

Top module: `cfg_space`

## Requirements
- R1: After reset the space is locked, `cfg_unlocked` is 0, `bus_rdata` is 0xFF, and the index and logical-device registers are 0x00.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x2E) unlocks the space, and `cfg_unlocked` is 1 from the cycle after the last key write. The data port is at address 0x2F.
- R3: While locked, an index-port write whose byte is not the next expected key byte sends the key tracker back to its first step. A complete key must then be written again. Data-port writes do not advance the tracker.
- R4: While locked, data-port writes change no register, and reads of either port return 0xFF. Index-port writes while locked do not change the latched index.
- R5: While unlocked, an index-port write latches the register number, and an index-port read returns it.
- R6: Index 0x07 is a read/write logical-device-number register with reset value 0x00.
- R7: Index 0x20 reads the high byte of the chip ID and 0x21 the low byte. Index 0x22 reads the revision in bits [3:0], with bits [7:4] zero. All three are read-only.
- R8: When the device number is 7, index 0x62 reads the high byte of the I/O base address and 0x63 the low byte. Both are read-only. Under any other device number, every index from 0x30 up reads 0xFF.
- R9: Every global index other than 0x07, 0x20, 0x21 and 0x22 reads 0xFF while unlocked.
- R10: While unlocked, writing 0x02 to the data port while the index is 0x02 locks the space. Any other data byte at index 0x02 leaves it unlocked.
- R11: `bus_rdata` is loaded at the clock edge where `bus_rd` is high and the address is one of the two ports. It holds its value across idle cycles, writes, and reads of other addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| cfg_unlocked | output | 1 | High while configuration access is open |

## Verification
The embedded properties assume that `bus_rd` and `bus_wr` are never high together, and that every strobe lasts exactly one cycle. The lock-state properties tie each change of `cfg_unlocked` to the single write on the cycle before. That holds only when there is one access per cycle. The bench drives every access from one task, which raises exactly one strobe for one cycle between falling edges and leaves an idle cycle after each access, so the stimulus always stays inside these assumptions.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int KEY_LEN = 4;
  localparam int STEP_W  = $clog2(KEY_LEN);

  localparam logic [7:0] EXIT_IDX    = 8'h02;
  localparam logic [7:0] EXIT_CODE   = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BANK_LO = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h62;
  localparam logic [7:0] IDX_BASE_LO = 8'h63;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;

  // Expected byte for each step of the unlock key, in order.
  function automatic logic [7:0] key_at(input logic [STEP_W-1:0] s);
    case (s)
      2'd0:    key_at = 8'h87;
      2'd1:    key_at = 8'h01;
      default: key_at = 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_gate.sv
module cfg_key_gate
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic [7:0] cur_index,
  output logic       unlocked
);
  logic [STEP_W-1:0] step;
  logic              key_hit;
  logic              key_last;
  logic              exit_cmd;

  assign key_hit  = (wdata == key_at(step));
  assign key_last = (step == STEP_W'(KEY_LEN - 1));
  assign exit_cmd = data_wr && (cur_index == EXIT_IDX) && (wdata == EXIT_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= '0;
      unlocked <= 1'b0;
    end else if (!unlocked) begin
      if (idx_wr) begin
        if (!key_hit) begin
          step <= '0;
        end else if (key_last) begin
          step     <= '0;
          unlocked <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end else if (exit_cmd) begin
      unlocked <= 1'b0;
    end
  end

  // R2
  unlock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_wr && wdata == 8'h55));

  // R10
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(data_wr && cur_index == EXIT_IDX && wdata == EXIT_CODE));

  // R3
  step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && idx_wr && wdata != key_at(step)) |=> (step == '0 && !unlocked));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV = 4'h3,
  parameter logic [15:0] IO_BASE  = 16'h0A00,
  parameter logic [7:0]  GPIO_LDN = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] index,
  output logic [7:0] ldn,
  output logic [7:0] rd_value
);
  logic [7:0] bank_value;
  logic [7:0] global_value;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index <= 8'h00;
      ldn   <= 8'h00;
    end else if (unlocked) begin
      if (idx_wr) index <= wdata;
      if (data_wr && index == IDX_LDN) ldn <= wdata;
    end
  end

  always_comb begin
    bank_value = IDLE_BYTE;
    if (ldn == GPIO_LDN) begin
      case (index)
        IDX_BASE_HI: bank_value = IO_BASE[15:8];
        IDX_BASE_LO: bank_value = IO_BASE[7:0];
        default:     bank_value = IDLE_BYTE;
      endcase
    end
  end

  always_comb begin
    case (index)
      IDX_LDN:   global_value = ldn;
      IDX_ID_HI: global_value = CHIP_ID[15:8];
      IDX_ID_LO: global_value = CHIP_ID[7:0];
      IDX_REV:   global_value = {4'h0, CHIP_REV};
      default:   global_value = IDLE_BYTE;
    endcase
  end

  assign rd_value = (index >= IDX_BANK_LO) ? bank_value : global_value;

  // R4
  locked_ldn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && data_wr) |=> $stable(ldn));

  // R6
  ldn_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ldn) |-> $past(unlocked && data_wr && index == IDX_LDN));

  // R5
  index_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(index) |-> $past(unlocked && idx_wr));
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h002E,
  parameter logic [15:0]       CHIP_ID    = 16'hA5C3,
  parameter logic [3:0]        CHIP_REV   = 4'h3,
  parameter logic [15:0]       IO_BASE    = 16'h0A00,
  parameter logic [7:0]        GPIO_LDN   = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cfg_unlocked
);
  localparam logic [ADDR_W-1:0] DATA_PORT = ADDR_W'(INDEX_PORT + 1);

  logic       idx_sel, data_sel, idx_wr, data_wr;
  logic       unlocked;
  logic [7:0] index, ldn, rd_value, port_value;

  assign idx_sel  = (bus_addr == INDEX_PORT);
  assign data_sel = (bus_addr == DATA_PORT);
  assign idx_wr   = bus_wr && idx_sel;
  assign data_wr  = bus_wr && data_sel;

  cfg_key_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .data_wr   (data_wr),
    .wdata     (bus_wdata),
    .cur_index (index),
    .unlocked  (unlocked)
  );

  cfg_regfile #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV),
    .IO_BASE  (IO_BASE),
    .GPIO_LDN (GPIO_LDN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (unlocked),
    .idx_wr   (idx_wr),
    .data_wr  (data_wr),
    .wdata    (bus_wdata),
    .index    (index),
    .ldn      (ldn),
    .rd_value (rd_value)
  );

  always_comb begin
    if (!unlocked)    port_value = IDLE_BYTE;
    else if (idx_sel) port_value = index;
    else              port_value = rd_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              bus_rdata <= IDLE_BYTE;
    else if (bus_rd && (idx_sel || data_sel)) bus_rdata <= port_value;
  end

  assign cfg_unlocked = unlocked;

  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (idx_sel || data_sel) && !unlocked) |=> (bus_rdata == IDLE_BYTE));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (idx_sel || data_sel)) |=> $stable(bus_rdata));
endmodule

// File: tb/tb_cfg_space.sv
`timescale 1ns/100ps
module tb_cfg_space;
  localparam logic [15:0] IDXP  = 16'h002E;
  localparam logic [15:0] DATP  = 16'h002F;
  localparam logic [15:0] ID    = 16'hA5C3;
  localparam logic [3:0]  REV   = 4'h3;
  localparam logic [15:0] BASE  = 16'h0A00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cfg_unlocked;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_space dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_unlocked(cfg_unlocked)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic unlock();
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
  endtask

  task automatic relock();
    wr(IDXP, 8'h02); wr(DATP, 8'h02);
  endtask

  function automatic int exp_reg(input int idx, input int ldn);
    if (idx >= 8'h30) begin
      if (ldn == 7 && idx == 8'h62) return BASE >> 8;
      if (ldn == 7 && idx == 8'h63) return BASE & 8'hFF;
      return 8'hFF;
    end
    case (idx)
      8'h07:   return ldn;
      8'h20:   return ID >> 8;
      8'h21:   return ID & 8'hFF;
      8'h22:   return REV;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 unlocked", cfg_unlocked, 0);
    check("R1 rdata", bus_rdata, 8'hFF);
    rd(IDXP, v); check("R1 locked idx read", v, 8'hFF);

    // R2 / R3 sweep the second key byte
    for (int b = 0; b < 256; b++) begin
      wr(IDXP, 8'h87); wr(IDXP, 8'(b)); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
      check(b == 1 ? "R2 key2" : "R3 key2", cfg_unlocked, b == 1);
      if (cfg_unlocked) relock();
    end
    // R2 / R3 sweep the last key byte
    for (int b = 0; b < 256; b++) begin
      wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'(b));
      check(b == 8'h55 ? "R2 key4" : "R3 key4", cfg_unlocked, b == 8'h55);
      if (cfg_unlocked) relock();
    end
    // R3 a repeated first byte is a mismatch and the sequence restarts
    wr(IDXP, 8'h87); wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    check("R3 restart", cfg_unlocked, 0);
    // R3 data writes neither advance nor break the tracker
    wr(IDXP, 8'h87); wr(DATP, 8'h01); wr(IDXP, 8'h01); wr(DATP, 8'h00);
    wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    check("R3 data ignored by tracker", cfg_unlocked, 1);

    // R6 the logical device register and R5 index readback
    wr(IDXP, 8'h07); rd(IDXP, v); check("R5 index readback", v, 8'h07);
    rd(DATP, v); check("R6 ldn reset", v, 8'h00);
    wr(DATP, 8'h05); rd(DATP, v); check("R6 ldn write", v, 8'h05);

    // R4 locked writes are ignored and locked reads give 0xFF
    relock();
    check("R10 exit", cfg_unlocked, 0);
    wr(DATP, 8'hAB); wr(DATP, 8'h07);
    rd(DATP, v); check("R4 locked data read", v, 8'hFF);
    unlock();
    rd(IDXP, v); check("R4 index kept", v, 8'h02);
    wr(IDXP, 8'h07); rd(DATP, v); check("R4 ldn kept", v, 8'h05);

    // R10 a wrong exit byte leaves the space open
    wr(IDXP, 8'h02); wr(DATP, 8'h03);
    check("R10 wrong exit", cfg_unlocked, 1);

    // R7 identity bytes are read-only
    wr(IDXP, 8'h20); wr(DATP, 8'h00); rd(DATP, v); check("R7 id ro", v, ID >> 8);
    wr(IDXP, 8'h22); wr(DATP, 8'hFF); rd(DATP, v); check("R7 rev ro", v, REV);

    // R7 R8 R9 full index sweep under two device numbers
    for (int l = 0; l < 2; l++) begin
      int ldnv;
      ldnv = (l == 0) ? 3 : 7;
      wr(IDXP, 8'h07); wr(DATP, 8'(ldnv));
      for (int i = 0; i < 256; i++) begin
        wr(IDXP, 8'(i)); rd(DATP, v);
        if (i >= 8'h30)                        check("R8 bank", v, exp_reg(i, ldnv));
        else if (i >= 8'h20 && i <= 8'h22)     check("R7 id", v, exp_reg(i, ldnv));
        else if (i == 8'h07)                   check("R6 ldn", v, exp_reg(i, ldnv));
        else                                   check("R9 unimpl", v, exp_reg(i, ldnv));
      end
    end
    // R8 the base address is read-only
    wr(IDXP, 8'h62); wr(DATP, 8'h00); rd(DATP, v); check("R8 base ro", v, BASE >> 8);

    // R11 read data holds across idle cycles, writes and foreign reads
    wr(IDXP, 8'h21); rd(DATP, v);
    repeat (3) @(negedge clk);
    check("R11 hold idle", bus_rdata, ID & 8'hFF);
    wr(IDXP, 8'h07);
    check("R11 hold write", bus_rdata, ID & 8'hFF);
    rd(16'h0080, v); check("R11 foreign read", v, ID & 8'hFF);

    relock();
    check("R10 final exit", cfg_unlocked, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule